// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the floating-point register storage of a processor core: 32 words of 32 bits, kept as two physical banks of 16 words. A one-bit bank mode, held in a register inside the block, decides which physical bank answers to the main register names and which answers to the alternate names. The alternate view always points at the bank that the main view is not using, so toggling the mode swaps the two banks without copying any data.

Each access names a view (main or alternate), an access size (one word, an aligned pair of words, or an aligned group of four words) and a register index within the view. There are two independent combinational read ports and one write port. The write port stores a whole pair or a whole group of four in a single cycle. Indices that are not aligned to the access size, and the reserved size code, are flagged as errors: such reads return zero and such writes change nothing. The datapath, status logic and exception handling of the floating-point unit sit outside this block. Only the storage, the bank aliasing and the access decoding are built here.

Top module: `banked_fpr_file`

## Requirements
- R1: While reset is applied, and after it is released, all 32 words read as zero and the bank mode (`mode_o`) is 0.
- R2: With mode 0, main-view index i (view code 0) reaches bank 0 word i, and alternate-view index i (view code 1) reaches bank 1 word i.
- R3: With mode 1, main-view index i reaches bank 1 word i, and alternate-view index i reaches bank 0 word i.
- R4: A mode write (`mode_we_i` high) takes effect at the next rising edge. Accesses in the same cycle still use the old bank mapping, and accesses from the next cycle use the new one.
- R5: Size code 1 (pair) with an even index n joins words n and n+1 of the selected view. Word n is on data bits [63:32], word n+1 is on [31:0], and bits [127:64] read as zero.
- R6: Size code 2 (group of four) with an index that is a multiple of 4 joins words n to n+3. Word n is on bits [127:96], word n+1 on [95:64], word n+2 on [63:32] and word n+3 on [31:0].
- R7: Size code 0 (single) with any index carries the word on bits [31:0], and bits [127:32] read as zero.
- R8: A write with size code 3, or with a pair index that is odd, or with a group index that is not a multiple of 4, changes no register. `wr_err_o` is high in that cycle.
- R9: A read with size code 3 or with a misaligned index returns all zeros, and its error output is high in that cycle. Aligned accesses keep their error output low.
- R10: Reads are combinational. A read of a register that is being written in the same cycle returns the old contents, and the new contents appear after the rising edge.
- R11: A single aligned write of a pair or a group of four updates all of its words at the same edge.
- R12: The two read ports decode their view, size and index independently of each other and of the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_we_i | input | 1 | Load the bank mode at the next edge |
| mode_i | input | 1 | New bank mode value |
| mode_o | output | 1 | Current bank mode |
| rd0_view_i | input | 1 | Read port 0 view: 0 main, 1 alternate |
| rd0_size_i | input | 2 | Read port 0 size: 0 single, 1 pair, 2 group of four, 3 reserved |
| rd0_idx_i | input | 4 | Read port 0 register index |
| rd0_data_o | output | 128 | Read port 0 data |
| rd0_err_o | output | 1 | Read port 0 misaligned or reserved access |
| rd1_view_i | input | 1 | Read port 1 view |
| rd1_size_i | input | 2 | Read port 1 size |
| rd1_idx_i | input | 4 | Read port 1 register index |
| rd1_data_o | output | 128 | Read port 1 data |
| rd1_err_o | output | 1 | Read port 1 misaligned or reserved access |
| wr_en_i | input | 1 | Write enable |
| wr_view_i | input | 1 | Write view |
| wr_size_i | input | 2 | Write size |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 128 | Write data, packed like read data |
| wr_err_o | output | 1 | Write is misaligned or reserved and is dropped |

## Verification
The state is the 32 stored words and the mode bit. All of it can be seen through the read ports in the cycle after any edge, because reads have no latency. A wrong bank mapping, a swapped pair or lane order, or a word damaged by a dropped write shows as a data mismatch on the first read of the affected name after the faulty edge. For that reason every view, size and index is read back under both mode values after random writes, and the results are compared with a flat 32-word model. A mode update that arrives one cycle early or late shows on a read that is held steady across the edge of the mode write.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;
  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic {
    VW_MAIN = 1'b0,
    VW_ALT  = 1'b1
  } acc_view_e;

  // number of words moved by one access of the given size code
  function automatic int unsigned lane_count(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/fpr_view_decode.sv
module fpr_view_decode
  import fpbank_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LANES = 4
) (
  input  logic             mode_i,
  input  logic             view_i,
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bank_o,
  output logic [IDX_W-1:0] base_o,
  output logic [LANES-1:0] lane_en_o,
  output logic             err_o
);
  localparam int SZ_MAX = $clog2(LANES);

  logic [IDX_W-1:0] align_mask;
  int unsigned      n_words;

  always_comb begin
    // alternate view always lands on the bank the main view leaves free
    bank_o     = mode_i ^ (acc_view_e'(view_i) == VW_ALT);
    base_o     = idx_i;
    lane_en_o  = '0;
    n_words    = lane_count(size_i);
    align_mask = IDX_W'(n_words - 1);
    if ((acc_size_e'(size_i) == SZ_RSVD) || (int'(size_i) > SZ_MAX)) begin
      err_o = 1'b1;
    end else begin
      err_o = |(idx_i & align_mask);
    end
    if (!err_o) begin
      for (int k = 0; k < LANES; k++) begin
        lane_en_o[k] = (k < int'(n_words));
      end
    end
  end
endmodule

// File: rtl/fpr_read_mux.sv
module fpr_read_mux #(
  parameter int WORD_W = 32,
  parameter int NPHYS  = 32,
  parameter int IDX_W  = 4,
  parameter int LANES  = 4
) (
  input  logic [NPHYS-1:0][WORD_W-1:0] regs_i,
  input  logic                         bank_i,
  input  logic [IDX_W-1:0]             base_i,
  input  logic [1:0]                   size_i,
  input  logic [LANES-1:0]             lane_en_i,
  output logic [LANES*WORD_W-1:0]      data_o
);
  logic [IDX_W:0] phys;
  int             slot;

  always_comb begin
    data_o = '0;
    phys   = '0;
    slot   = 0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_en_i[k]) begin
        // lowest register index goes to the most significant slot
        slot = int'(fpbank_pkg::lane_count(size_i)) - 1 - k;
        phys = {bank_i, base_i + IDX_W'(k)};
        if (slot >= 0) begin
          data_o[slot*WORD_W +: WORD_W] = regs_i[phys];
        end
      end
    end
  end
endmodule

// File: rtl/fpr_bank_store.sv
module fpr_bank_store #(
  parameter int WORD_W = 32,
  parameter int NPHYS  = 32,
  parameter int IDX_W  = 4,
  parameter int LANES  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic                         wr_err_i,
  input  logic                         bank_i,
  input  logic [IDX_W-1:0]             base_i,
  input  logic [1:0]                   size_i,
  input  logic [LANES-1:0]             lane_en_i,
  input  logic [LANES*WORD_W-1:0]      wdata_i,
  output logic [NPHYS-1:0][WORD_W-1:0] regs_o
);
  logic [NPHYS-1:0][WORD_W-1:0] regs_q;
  logic [NPHYS-1:0][WORD_W-1:0] wword;
  logic [NPHYS-1:0]             wen;
  logic [IDX_W:0]               phys;
  int                           slot;

  // next-state: per-register enable and data
  always_comb begin
    wen   = '0;
    wword = '0;
    phys  = '0;
    slot  = 0;
    for (int k = 0; k < LANES; k++) begin
      if (wr_en_i && lane_en_i[k]) begin
        slot = int'(fpbank_pkg::lane_count(size_i)) - 1 - k;
        phys = {bank_i, base_i + IDX_W'(k)};
        if (slot >= 0) begin
          wen[phys]   = 1'b1;
          wword[phys] = wdata_i[slot*WORD_W +: WORD_W];
        end
      end
    end
  end

  for (genvar i = 0; i < NPHYS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (wen[i]) begin
        regs_q[i] <= wword[i];
      end
    end
  end

  assign regs_o = regs_q;

  assert_bad_write_dropped_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_err_i) |=> $stable(regs_q)
  );

  assert_single_write_lands_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_err_i && size_i == 2'd0)
      |=> regs_q[$past({bank_i, base_i})] == $past(wdata_i[WORD_W-1:0])
  );
endmodule

// File: rtl/banked_fpr_file.sv
module banked_fpr_file #(
  parameter int WORD_W    = 32,
  parameter int BANK_REGS = 16,
  parameter int MAX_LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_we_i,
  input  logic                          mode_i,
  output logic                          mode_o,
  input  logic                          rd0_view_i,
  input  logic [1:0]                    rd0_size_i,
  input  logic [$clog2(BANK_REGS)-1:0]  rd0_idx_i,
  output logic [MAX_LANES*WORD_W-1:0]   rd0_data_o,
  output logic                          rd0_err_o,
  input  logic                          rd1_view_i,
  input  logic [1:0]                    rd1_size_i,
  input  logic [$clog2(BANK_REGS)-1:0]  rd1_idx_i,
  output logic [MAX_LANES*WORD_W-1:0]   rd1_data_o,
  output logic                          rd1_err_o,
  input  logic                          wr_en_i,
  input  logic                          wr_view_i,
  input  logic [1:0]                    wr_size_i,
  input  logic [$clog2(BANK_REGS)-1:0]  wr_idx_i,
  input  logic [MAX_LANES*WORD_W-1:0]   wr_data_i,
  output logic                          wr_err_o
);
  localparam int IDX_W  = $clog2(BANK_REGS);
  localparam int NPHYS  = 2 * BANK_REGS;
  localparam int DATA_W = MAX_LANES * WORD_W;
  localparam int NPORT  = 3;  // two read ports, then the write port
  localparam int NRD    = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // bank mode register
  logic mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we_i) mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end
  assign mode_o = mode_q;

  // per-port decode
  logic                   p_view [NPORT];
  logic [1:0]             p_size [NPORT];
  logic [IDX_W-1:0]       p_idx  [NPORT];
  logic                   p_bank [NPORT];
  logic [IDX_W-1:0]       p_base [NPORT];
  logic [MAX_LANES-1:0]   p_lane [NPORT];
  logic                   p_err  [NPORT];
  logic [DATA_W-1:0]      p_data [NRD];

  assign p_view[0] = rd0_view_i;
  assign p_size[0] = rd0_size_i;
  assign p_idx[0]  = rd0_idx_i;
  assign p_view[1] = rd1_view_i;
  assign p_size[1] = rd1_size_i;
  assign p_idx[1]  = rd1_idx_i;
  assign p_view[2] = wr_view_i;
  assign p_size[2] = wr_size_i;
  assign p_idx[2]  = wr_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    fpr_view_decode #(
      .IDX_W (IDX_W),
      .LANES (MAX_LANES)
    ) dec_i (
      .mode_i    (mode_q),
      .view_i    (p_view[p]),
      .size_i    (p_size[p]),
      .idx_i     (p_idx[p]),
      .bank_o    (p_bank[p]),
      .base_o    (p_base[p]),
      .lane_en_o (p_lane[p]),
      .err_o     (p_err[p])
    );
  end

  logic [NPHYS-1:0][WORD_W-1:0] regs;

  fpr_bank_store #(
    .WORD_W (WORD_W),
    .NPHYS  (NPHYS),
    .IDX_W  (IDX_W),
    .LANES  (MAX_LANES)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_err_i  (p_err[2]),
    .bank_i    (p_bank[2]),
    .base_i    (p_base[2]),
    .size_i    (p_size[2]),
    .lane_en_i (p_lane[2]),
    .wdata_i   (wr_data_i),
    .regs_o    (regs)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    fpr_read_mux #(
      .WORD_W (WORD_W),
      .NPHYS  (NPHYS),
      .IDX_W  (IDX_W),
      .LANES  (MAX_LANES)
    ) mux_i (
      .regs_i    (regs),
      .bank_i    (p_bank[r]),
      .base_i    (p_base[r]),
      .size_i    (p_size[r]),
      .lane_en_i (p_lane[r]),
      .data_o    (p_data[r])
    );
  end

  assign rd0_data_o = p_data[0];
  assign rd1_data_o = p_data[1];
  assign rd0_err_o  = p_err[0];
  assign rd1_err_o  = p_err[1];
  assign wr_err_o   = wr_en_i & p_err[2];

  assert_mode_next_cycle_R4: assert property (
    @(posedge clk) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == $past(mode_i))
  );

  assert_mode_held_R4: assert property (
    @(posedge clk) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o)
  );

  assert_bad_read_zero_R9: assert property (
    @(posedge clk) disable iff (!rst_ni)
    (rd0_err_o |-> rd0_data_o == '0) and (rd1_err_o |-> rd1_data_o == '0)
  );
endmodule

// File: tb/banked_fpr_file_tb.sv
module banked_fpr_file_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_we, mode_in, mode_out;
  logic         r0_view, r1_view, w_view, w_en;
  logic [1:0]   r0_size, r1_size, w_size;
  logic [3:0]   r0_idx, r1_idx, w_idx;
  logic [127:0] r0_data, r1_data, w_data;
  logic         r0_err, r1_err, w_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];
  bit md = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_fpr_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .mode_we_i(mode_we), .mode_i(mode_in), .mode_o(mode_out),
    .rd0_view_i(r0_view), .rd0_size_i(r0_size), .rd0_idx_i(r0_idx),
    .rd0_data_o(r0_data), .rd0_err_o(r0_err),
    .rd1_view_i(r1_view), .rd1_size_i(r1_size), .rd1_idx_i(r1_idx),
    .rd1_data_o(r1_data), .rd1_err_o(r1_err),
    .wr_en_i(w_en), .wr_view_i(w_view), .wr_size_i(w_size), .wr_idx_i(w_idx),
    .wr_data_i(w_data), .wr_err_o(w_err)
  );

  function automatic bit exp_bad(int sz, int ix);
    if (sz == 3) return 1'b1;
    return (ix % (1 << sz)) != 0;
  endfunction

  function automatic logic [127:0] exp_read(bit m, bit vw, int sz, int ix);
    logic [127:0] r = '0;
    int n;
    int bank;
    if (exp_bad(sz, ix)) return '0;
    n = 1 << sz;
    bank = int'(m ^ vw);
    for (int k = 0; k < n; k++) r[(n-1-k)*32 +: 32] = model[bank*16 + ix + k];
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic probe(string req, bit vw, int sz, int ix, int port);
    @(negedge clk);
    if (port == 0) begin r0_view = vw; r0_size = 2'(sz); r0_idx = 4'(ix); end
    else           begin r1_view = vw; r1_size = 2'(sz); r1_idx = 4'(ix); end
    #1;
    if (port == 0) begin
      chk(req, r0_data, exp_read(md, vw, sz, ix));
      chk(req, {127'd0, r0_err}, {127'd0, exp_bad(sz, ix)});
    end else begin
      chk(req, r1_data, exp_read(md, vw, sz, ix));
      chk(req, {127'd0, r1_err}, {127'd0, exp_bad(sz, ix)});
    end
  endtask

  task automatic do_write(string req, bit vw, int sz, int ix, logic [127:0] d);
    int n;
    int bank;
    @(negedge clk);
    w_en = 1'b1; w_view = vw; w_size = 2'(sz); w_idx = 4'(ix); w_data = d;
    #1;
    chk(req, {127'd0, w_err}, {127'd0, exp_bad(sz, ix)});
    @(posedge clk);
    #1;
    w_en = 1'b0;
    if (!exp_bad(sz, ix)) begin
      n = 1 << sz;
      bank = int'(md ^ vw);
      for (int k = 0; k < n; k++) model[bank*16 + ix + k] = d[(n-1-k)*32 +: 32];
    end
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    mode_we = 1'b1; mode_in = m;
    @(posedge clk);
    #1;
    mode_we = 1'b0;
    md = m;
  endtask

  // R2 R3 R5 R6 R7 R9 R12: every view, size and index on both ports
  task automatic sweep(string req);
    for (int vw = 0; vw < 2; vw++)
      for (int sz = 0; sz < 4; sz++)
        for (int ix = 0; ix < 16; ix++) begin
          probe(req, bit'(vw), sz, ix, 0);
          probe(req, bit'(vw ^ 1), (sz + 1) % 4, 15 - ix, 1);
        end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mode", {127'd0, mode_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    chk("R1 mode after release", {127'd0, mode_out}, '0);
    for (int ix = 0; ix < 16; ix += 4) begin
      probe("R1", 1'b0, 2, ix, 0);
      probe("R1", 1'b1, 2, ix, 1);
    end
  endtask

  task automatic t_random_fill;
    for (int i = 0; i < 40; i++) begin
      int sz = $urandom_range(0, 2);
      int ix = $urandom_range(0, 15) & ~((1 << sz) - 1);
      do_write("R11 random", bit'($urandom_range(0, 1)), sz, ix,
               {$urandom, $urandom, $urandom, $urandom});
    end
  endtask

  task automatic t_views_both_modes;
    set_mode(1'b0);
    sweep("R2 mode0");
    set_mode(1'b1);
    t_random_fill();
    sweep("R3 mode1");
    set_mode(1'b0);
    sweep("R2 mode0 again");
  endtask

  task automatic t_lane_order;
    do_write("R6 quad", 1'b0, 2, 8, 128'h11111111_22222222_33333333_44444444);
    probe("R6 quad order", 1'b0, 2, 8, 0);
    probe("R7 single n+3", 1'b0, 0, 11, 1);
    chk("R7 word low", r1_data, 128'h44444444);
    probe("R5 pair order", 1'b0, 1, 10, 0);
    chk("R5 pair value", r0_data, 128'h33333333_44444444);
    do_write("R11 alt pair", 1'b1, 1, 14, 128'hdead_beef_0000_0000_aaaa5555_0f0f0f0f);
    probe("R5 alt pair", 1'b1, 1, 14, 0);
    chk("R5 alt pair value", r0_data, 128'h0000_0000_0000_0000_aaaa5555_0f0f0f0f);
  endtask

  task automatic t_misaligned;
    do_write("R8 odd pair", 1'b0, 1, 3, {4{32'hbad0bad0}});
    do_write("R8 quad idx6", 1'b1, 2, 6, {4{32'hbad1bad1}});
    do_write("R8 size3", 1'b0, 3, 0, {4{32'hbad2bad2}});
    for (int ix = 0; ix < 16; ix += 4) begin
      probe("R8 untouched main", 1'b0, 2, ix, 0);
      probe("R8 untouched alt", 1'b1, 2, ix, 1);
    end
    probe("R9 odd pair read", 1'b0, 1, 5, 0);
    probe("R9 quad idx2 read", 1'b1, 2, 2, 1);
    probe("R9 size3 read", 1'b0, 3, 4, 0);
  endtask

  task automatic t_read_during_write;
    logic [127:0] old_v;
    logic [127:0] nv = 128'hcafe0001_cafe0002;
    @(negedge clk);
    r0_view = 1'b0; r0_size = 2'd1; r0_idx = 4'd2;
    r1_view = 1'b0; r1_size = 2'd2; r1_idx = 4'd0;
    w_en = 1'b1; w_view = 1'b0; w_size = 2'd1; w_idx = 4'd2; w_data = nv;
    #1;
    old_v = exp_read(md, 1'b0, 1, 2);
    chk("R10 old value", r0_data, old_v);
    @(posedge clk);
    #1;
    w_en = 1'b0;
    model[int'(md)*16 + 2] = nv[63:32];
    model[int'(md)*16 + 3] = nv[31:0];
    chk("R10 new value", r0_data, {64'd0, nv[63:0]});
    chk("R11 quad sees pair", r1_data, exp_read(md, 1'b0, 2, 0));
  endtask

  task automatic t_mode_timing;
    bit old_m = md;
    @(negedge clk);
    r0_view = 1'b0; r0_size = 2'd0; r0_idx = 4'd9;
    r1_view = 1'b1; r1_size = 2'd0; r1_idx = 4'd9;
    mode_we = 1'b1; mode_in = ~old_m;
    #1;
    chk("R4 same cycle main", r0_data, exp_read(old_m, 1'b0, 0, 9));
    chk("R4 same cycle alt", r1_data, exp_read(old_m, 1'b1, 0, 9));
    @(posedge clk);
    #1;
    mode_we = 1'b0;
    md = ~old_m;
    chk("R4 mode out", {127'd0, mode_out}, {127'd0, md});
    chk("R4 next cycle main", r0_data, exp_read(md, 1'b0, 0, 9));
    chk("R4 next cycle alt", r1_data, exp_read(md, 1'b1, 0, 9));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    mode_we = 0; mode_in = 0; w_en = 0; w_view = 0; w_size = 0; w_idx = 0; w_data = '0;
    r0_view = 0; r0_size = 0; r0_idx = 0; r1_view = 0; r1_size = 0; r1_idx = 0;
    t_reset();
    t_random_fill();
    t_views_both_modes();
    t_lane_order();
    t_misaligned();
    t_read_during_write();
    t_mode_timing();
    t_mode_timing();
    sweep("R12 final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule